// File: doc/BRIEF.md
# Raw Sample Direct Serializer

This block takes one raw 10-bit sample from each of 32 acquisition channels in every sampling period. It streams the samples, unchanged, onto ten parallel serial links. The serial clock runs 32 times faster than the sampling rate, so each period is 32 serial cycles long. An eleventh link carries the sampling clock, divided down from the serial clock. A receiver can count the high and low runs on that link to find a phase jump caused by an upset in the divider.

Two modes are available. In normal mode, each serial cycle puts one whole sample on all ten links, and the channels follow one another in ascending order. In split mode, the links form two groups of five. Each group carries half of the channels as 5-bit halves, lower half first. This lets two separate receivers each take one half of the channels.

The stream has no framing bits because its position is implied by the cycle count. After reset, and after every restart request, one whole period of a known pattern is sent in place of data. This lets the receiver lock onto the period and check that no link is stuck.

Top module: `raw_serializer`

## Requirements
- R1: `sampleStrobe_o` is high for exactly one cycle in every 32. It marks the last cycle of each period (slot 31), and it is first high 31 cycles after reset is released.
- R2: In a normal-mode data period, during slot c, `links_o[9:0]` equals the captured sample of channel c. Channel c occupies `samples_i[c*10 +: 10]`.
- R3: In a split-mode data period, during slot c, let k = c/2. When c is even, `links_o[4:0]` is bits 4..0 of channel k and `links_o[9:5]` is bits 4..0 of channel k+16. When c is odd, the same links carry bits 9..5 of those two channels.
- R4: The first period after reset is a sync period. During slot c, link j (0..9) outputs bit (j mod 5) of c, inverted for j ≥ 5, so every data link toggles within the period.
- R5: A restart request makes the next period a sync period. A request in any cycle of a period takes effect at the following boundary. This includes a request made in the strobe cycle itself.
- R6: `links_o[10]` is high in slots 0..15 and low in slots 16..31, in every period, including sync periods.
- R7: The samples are captured only at the clock edge that ends the strobe cycle, and they are shown during the period that follows. Changes on `samples_i` at any other time do not change the links.
- R8: `splitMode_i` is sampled at the same edge as the samples. A mode change in the middle of a period does not affect the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samples_i | input | 320 | 32 samples of 10 bits, channel c at bits c*10+9..c*10 |
| splitMode_i | input | 1 | 1 selects split mode, 0 selects normal mode |
| restart_i | input | 1 | Request to resend the sync period |
| links_o | output | 11 | Bits 9..0 are the data links; bit 10 is the sampling clock |
| sampleStrobe_o | output | 1 | High in the last slot of each period, when the samples are captured |

## Verification
Three things can fall on the same cycle: a restart request, the strobe cycle that captures the samples, and a mode change. The bench raises restart exactly in a strobe cycle and also in the first slot after one. It raises restart during a sync period, and it toggles the mode at mid-period positions. A per-cycle model predicts every link bit, which shows whether the restart went to the right period and whether the capture still went ahead. The sample inputs change every cycle, so any capture outside the strobe cycle shows up in the link values.

// File: rtl/rawser_pkg.sv
package rawser_pkg;
  // Slot index carried to the datapath. It is wide enough for any power-of-two channel count up to 256.
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              loadHold;   // capture samples at this edge
    logic              sendSync;   // current period is a sync period
    logic              splitSel;   // current period uses split mode
    logic              upperHalf;  // split mode: upper half-sample slot
    logic              clkLevel;   // derived sampling clock level
    logic [SLOT_W-1:0] slot;       // position within the period
  } rawser_ctl_t;
endpackage

// File: rtl/rawser_ctrl.sv
module rawser_ctrl
  import rawser_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        splitMode_i,
  input  logic        restart_i,
  output rawser_ctl_t ctl_o
);
  localparam int CNT_W = $clog2(NUM_CH);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(NUM_CH - 1);

  logic [CNT_W-1:0] slotCnt;
  logic             syncActive;
  logic             restartPend;
  logic             splitLatched;
  logic             atBoundary;

  assign atBoundary = (slotCnt == LAST_SLOT);

  // Free-running position counter; the period length is a power of two.
  always_ff @(posedge clk) begin
    if (!rst_n) slotCnt <= '0;
    else        slotCnt <= slotCnt + 1'b1;
  end

  // Period-level state changes only at the boundary edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncActive   <= 1'b1;
      restartPend  <= 1'b0;
      splitLatched <= 1'b0;
    end else if (atBoundary) begin
      syncActive   <= restartPend | restart_i;
      restartPend  <= 1'b0;
      splitLatched <= splitMode_i;
    end else if (restart_i) begin
      restartPend  <= 1'b1;
    end
  end

  always_comb begin
    ctl_o.loadHold  = atBoundary;
    ctl_o.sendSync  = syncActive;
    ctl_o.splitSel  = splitLatched;
    ctl_o.upperHalf = slotCnt[0];
    ctl_o.clkLevel  = ~slotCnt[CNT_W-1];
    ctl_o.slot      = SLOT_W'(slotCnt);
  end
endmodule

// File: rtl/rawser_datapath.sv
module rawser_datapath
  import rawser_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int SAMPLE_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH*SAMPLE_W-1:0]   samples_i,
  input  rawser_ctl_t                  ctl_i,
  output logic [SAMPLE_W-1:0]          dataLinks_o
);
  localparam int CNT_W  = $clog2(NUM_CH);
  localparam int HALF_W = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] holdReg [NUM_CH];
  logic [SAMPLE_W-1:0] syncWord;
  logic [SAMPLE_W-1:0] normalWord;
  logic [SAMPLE_W-1:0] splitWord;
  logic [SAMPLE_W-1:0] loWord;
  logic [SAMPLE_W-1:0] hiWord;
  logic [CNT_W-2:0]    pairIdx;

  // Holding register: one capture per period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NUM_CH; ch++) holdReg[ch] <= '0;
    end else if (ctl_i.loadHold) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        holdReg[ch] <= samples_i[ch*SAMPLE_W +: SAMPLE_W];
    end
  end

  // Sync pattern: each link follows one counter bit, and the upper group is inverted.
  for (genvar j = 0; j < SAMPLE_W; j++) begin : g_sync
    localparam logic INV = (j >= HALF_W);
    assign syncWord[j] = ctl_i.slot[j % CNT_W] ^ INV;
  end

  assign normalWord = holdReg[ctl_i.slot[CNT_W-1:0]];
  assign pairIdx    = ctl_i.slot[CNT_W-1:1];
  assign loWord     = holdReg[{1'b0, pairIdx}];
  assign hiWord     = holdReg[{1'b1, pairIdx}];

  for (genvar j = 0; j < HALF_W; j++) begin : g_split
    assign splitWord[j]          = ctl_i.upperHalf ? loWord[j + HALF_W] : loWord[j];
    assign splitWord[j + HALF_W] = ctl_i.upperHalf ? hiWord[j + HALF_W] : hiWord[j];
  end

  always_comb begin
    if (ctl_i.sendSync)      dataLinks_o = syncWord;
    else if (ctl_i.splitSel) dataLinks_o = splitWord;
    else                     dataLinks_o = normalWord;
  end
endmodule

// File: rtl/raw_serializer.sv
module raw_serializer
  import rawser_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  input  logic                       splitMode_i,
  input  logic                       restart_i,
  output logic [SAMPLE_W:0]          links_o,
  output logic                       sampleStrobe_o
);
  rawser_ctl_t         strobes;
  logic [SAMPLE_W-1:0] dataLinks;

  rawser_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .splitMode_i(splitMode_i),
    .restart_i  (restart_i),
    .ctl_o      (strobes)
  );

  rawser_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .samples_i  (samples_i),
    .ctl_i      (strobes),
    .dataLinks_o(dataLinks)
  );

  assign links_o        = {strobes.clkLevel, dataLinks};
  assign sampleStrobe_o = strobes.loadHold;
endmodule

// File: rtl/raw_serializer_checker.sv
module raw_serializer_checker
  import rawser_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        restart_i,
  input logic        sampleStrobe_o,
  input logic        clkLink,
  input rawser_ctl_t ctl
);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe_o |=> !sampleStrobe_o);

  p_clk_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkLink) |-> $past(sampleStrobe_o));

  p_clk_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkLink) |-> ($past(ctl.slot) == SLOT_W'(NUM_CH/2 - 1)));

  p_restart_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStrobe_o && restart_i) |=> ctl.sendSync);

  p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sampleStrobe_o) |-> $stable(ctl.sendSync));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sampleStrobe_o) |-> $stable(ctl.splitSel));
endmodule

bind raw_serializer raw_serializer_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .restart_i     (restart_i),
  .sampleStrobe_o(sampleStrobe_o),
  .clkLink       (links_o[SAMPLE_W]),
  .ctl           (strobes)
);

// File: tb/raw_serializer_bench.sv
module raw_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int SW  = 10;
  localparam int TOTAL_CYCLES = 32 * 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*SW-1:0] samples_i = '0;
  logic              splitMode_i = 1'b0;
  logic              restart_i = 1'b0;
  logic [SW:0]       links_o;
  logic              sampleStrobe_o;

  int vecCount  = 0;
  int failCount = 0;

  // Reference state, advanced from the requirements
  logic [4:0]    ec = '0;
  logic          esync = 1'b1;
  logic          epend = 1'b0;
  logic          emode = 1'b0;
  logic [SW-1:0] ehold [NCH];

  raw_serializer u_raw_serializer (
    .clk(clk), .rst_n(rst_n), .samples_i(samples_i),
    .splitMode_i(splitMode_i), .restart_i(restart_i),
    .links_o(links_o), .sampleStrobe_o(sampleStrobe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW:0] expLinks();
    logic [SW:0] v;
    int k;
    v[SW] = (ec < 16);                                   // R6
    if (esync) begin                                     // R4
      for (int j = 0; j < SW; j++) v[j] = ec[j % 5] ^ (j >= 5);
    end else if (emode) begin                            // R3
      k = int'(ec) / 2;
      for (int j = 0; j < 5; j++) begin
        v[j]   = ec[0] ? ehold[k][j+5]    : ehold[k][j];
        v[j+5] = ec[0] ? ehold[k+16][j+5] : ehold[k+16][j];
      end
    end else begin                                       // R2
      v[SW-1:0] = ehold[ec];
    end
    return v;
  endfunction

  task automatic checkOutputs();
    logic [SW:0] e;
    string tag;
    e = expLinks();
    tag = esync ? "R4/R5" : (emode ? "R3/R7/R8" : "R2/R7/R8");
    vecCount++;
    if (links_o[SW-1:0] !== e[SW-1:0]) begin
      failCount++;
      $display("FAIL %s slot %0d: links=%h expected %h", tag, ec, links_o[SW-1:0], e[SW-1:0]);
    end
    vecCount++;
    if (links_o[SW] !== e[SW]) begin
      failCount++;
      $display("FAIL R6 slot %0d: clock link=%b expected %b", ec, links_o[SW], e[SW]);
    end
    vecCount++;
    if (sampleStrobe_o !== (ec == 5'd31)) begin
      failCount++;
      $display("FAIL R1 slot %0d: strobe=%b expected %b", ec, sampleStrobe_o, (ec == 5'd31));
    end
  endtask

  function automatic logic [SW-1:0] sampleVal(int t, int c);
    int p = t / 32;
    if (p == 7)  return '1;
    if (p == 8)  return (c % 2 == 0) ? 10'h155 : 10'h2AA;
    if (p == 9)  return '0;
    return SW'((c * 73 + t * 29 + 11) % 1024);
  endfunction

  // The mode changes at slot 19, in the middle of a period (R8).
  function automatic logic modeFor(int t);
    int q = (t + 13) / 32;
    return (q == 3) || (q == 4) || (q == 5) || (q == 8) || (q == 11) || (q == 12) || (q >= 16 && q <= 20);
  endfunction

  // Restart in mid-period, in the strobe cycle, just after a boundary, and during sync (R5)
  function automatic logic restartFor(int t);
    return (t == 200) || (t == 351) || (t == 352) || (t == 460) || (t == 575) || (t == 700);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) ehold[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: a sync pattern at slot 0 with the clock link high and no strobe (R4, R6, R1)
    vecCount++;
    if (links_o !== 11'h7E0) begin
      failCount++;
      $display("FAIL R4 reset: links=%h expected %h", links_o, 11'h7E0);
    end
    vecCount++;
    if (sampleStrobe_o !== 1'b0) begin
      failCount++;
      $display("FAIL R1 reset: strobe=%b expected 0", sampleStrobe_o);
    end
    rst_n = 1'b1;
    for (int t = 0; t < TOTAL_CYCLES; t++) begin
      checkOutputs();
      // The samples change every cycle, so a capture at the wrong time is visible (R7)
      for (int c = 0; c < NCH; c++) samples_i[c*SW +: SW] = sampleVal(t, c);
      splitMode_i = modeFor(t);
      restart_i   = restartFor(t);
      @(posedge clk);
      if (ec == 5'd31) begin
        for (int c = 0; c < NCH; c++) ehold[c] = samples_i[c*SW +: SW];
        emode = splitMode_i;
        esync = epend | restart_i;
        epend = 1'b0;
      end else if (restart_i) begin
        epend = 1'b1;
      end
      ec = ec + 5'd1;
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog expired: cycles=%0d expected %0d", 200000, TOTAL_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule